// File: doc/BRIEF.md
# Two-Cell Pack Protection Sequencer

This block sequences the protection switches of a pack with two lithium-ion cells in series. Each cycle it takes both cell voltages as unsigned millivolt samples, plus a signed millivolt sample of the current-sense node. A one-cycle `tick` strobe arrives once per millisecond. From these inputs it keeps two enables registered: one for the charge path switch and one for the discharge path switch.

A cell that stays too high for a qualification window turns charging off. A cell that stays too low for a window turns discharging off. Each trip is remembered against the cell or cells that caused it. The inhibit lifts in the first cycle after every such cell crosses back past its release level. An undervoltage trip also puts the block into a sleep mode. In sleep mode all timing stops, apart from overvoltage watching on the cell that did not trip low. The block leaves sleep only when the sense node shows a charger pulling the pack negative.

A three-bit code replaces the external timing capacitor and sets the qualification window in milliseconds. A two-bit variant code sets the overvoltage level.

Top module: `cell_guard_ctrl`

## Requirements
- R1: Charging is disabled (`chg_en` low) when either cell stays strictly above the overvoltage level for the full window. The level is 4350 mV for `trip_var` 0, 4300 mV for 1, and 4250 mV for 2 or 3. The trip shows on `chg_en` after the N-th consecutive tick-qualified clock edge.
- R2: Once charging is disabled, `chg_en` returns high one edge after every cell that caused the trip is below 4000 mV. The other cell's voltage has no effect on this.
- R3: Discharging is disabled (`dsg_en` low) when either cell stays strictly below 2400 mV for the full window.
- R4: In normal mode, `dsg_en` returns high one edge after every cell that caused the undervoltage trip is strictly above 3000 mV. A cell at exactly 3000 mV does not release it.
- R5: `dly_sel` sets the window N in ticks as follows: 0→25, 1→320, 2→850, 3→1100, and 4 to 7→1400.
- R6: An undervoltage trip raises `low_power` on the same edge that drops `dsg_en`. In sleep, `dsg_en` stays low even after the cell recovers, and undervoltage timing is stopped.
- R7: In sleep, overvoltage trip and release still work on any cell that did not cause the undervoltage trip.
- R8: In sleep, a `sense_mv` value strictly below -400 clears `low_power` on the next edge. A value of exactly -400 does not.
- R9: `chg_en` stays high while discharging is inhibited, unless an overvoltage trip of its own occurs.
- R10: If a threshold excursion ends before its window completes, that window counter restarts from zero.
- R11: A synchronous active-high `rst` sets `chg_en` and `dsg_en` high and `low_power` low, and clears all counters.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle strobe per millisecond |
| cell_a_mv | input | 13 | Lower cell voltage, mV, unsigned |
| cell_b_mv | input | 13 | Upper cell voltage, mV, unsigned |
| sense_mv | input | 12 | Sense node voltage, mV, two's complement |
| trip_var | input | 2 | Overvoltage level variant |
| dly_sel | input | 3 | Qualification window code |
| chg_en | output | 1 | Charge switch enable |
| dsg_en | output | 1 | Discharge switch enable |
| low_power | output | 1 | Sleep mode flag |

## Verification
The hardest state to reach is an overvoltage trip that happens while the block is asleep after an undervoltage trip. It needs one cell held low for a full window while the other is then pushed high for a second full window, with no charger present. The stimulus table builds this state step by step and then releases it in sleep. After that it wakes the block with a charger while the low cell is still down, and walks that cell across the 3000 mV release boundary. Run-length checks sample one edge before and one edge after each window, so an off-by-one in the counters shows up.

// File: rtl/cell_guard_pkg.sv
package cell_guard_pkg;
  typedef enum logic {
    MODE_RUN   = 1'b0,
    MODE_SLEEP = 1'b1
  } guard_mode_t;

  // index of each qualification timer
  localparam int unsigned TMR_OVC = 0;
  localparam int unsigned TMR_OVD = 1;
  localparam int unsigned NTMR    = 2;
endpackage

// File: rtl/cg_level_cmp.sv
module cg_level_cmp #(
  parameter int unsigned MV_W   = 13,
  parameter int unsigned NCELL  = 2,
  parameter int unsigned HI_REL = 4000,
  parameter int unsigned LO_MV  = 2400,
  parameter int unsigned LO_REL = 3000
) (
  input  logic [NCELL-1:0][MV_W-1:0] cell_mv,
  input  logic [MV_W-1:0]            hi_mv,
  output logic [NCELL-1:0]           over_hi,
  output logic [NCELL-1:0]           below_rel,
  output logic [NCELL-1:0]           under_lo,
  output logic [NCELL-1:0]           above_rel
);
  localparam logic [MV_W-1:0] HI_REL_L = MV_W'(HI_REL);
  localparam logic [MV_W-1:0] LO_L     = MV_W'(LO_MV);
  localparam logic [MV_W-1:0] LO_REL_L = MV_W'(LO_REL);

  for (genvar c = 0; c < NCELL; c++) begin : g_cell
    always_comb begin
      over_hi[c]   = cell_mv[c] > hi_mv;
      below_rel[c] = cell_mv[c] < HI_REL_L;
      under_lo[c]  = cell_mv[c] < LO_L;
      above_rel[c] = cell_mv[c] > LO_REL_L;
    end
  end
endmodule

// File: rtl/cg_delay_map.sv
module cg_delay_map #(
  parameter int unsigned CNT_W = 11,
  parameter int unsigned T0    = 25,
  parameter int unsigned T1    = 320,
  parameter int unsigned T2    = 850,
  parameter int unsigned T3    = 1100,
  parameter int unsigned T4    = 1400
) (
  input  logic [2:0]       code,
  output logic [CNT_W-1:0] limit
);
  always_comb begin
    case (code)
      3'd0:    limit = CNT_W'(T0);
      3'd1:    limit = CNT_W'(T1);
      3'd2:    limit = CNT_W'(T2);
      3'd3:    limit = CNT_W'(T3);
      default: limit = CNT_W'(T4);
    endcase
  end
endmodule

// File: rtl/cg_qual_timer.sv
module cg_qual_timer #(
  parameter int unsigned CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             run,
  input  logic [CNT_W-1:0] limit,
  output logic             expire
);
  logic [CNT_W-1:0] cnt;

  assign expire = run && tick && (cnt >= (limit - CNT_W'(1)));

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
    end else if (tick) begin
      if (expire) cnt <= '0;
      else        cnt <= cnt + CNT_W'(1);
    end
  end

  AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (rst)
    !run |=> (cnt == '0)); // R10

  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (rst)
    (run && !tick && $past(run)) |=> $stable(cnt) || !run); // R10
endmodule

// File: rtl/cell_guard_ctrl.sv
module cell_guard_ctrl
  import cell_guard_pkg::*;
#(
  parameter int unsigned MV_W    = 13,
  parameter int unsigned SNS_W   = 12,
  parameter int unsigned HI_MV0  = 4350,
  parameter int unsigned HI_MV1  = 4300,
  parameter int unsigned HI_MV2  = 4250,
  parameter int unsigned HI_REL  = 4000,
  parameter int unsigned LO_MV   = 2400,
  parameter int unsigned LO_REL  = 3000,
  parameter int          WAKE_MV = -400,
  parameter int unsigned DLY_T0  = 25,
  parameter int unsigned DLY_T1  = 320,
  parameter int unsigned DLY_T2  = 850,
  parameter int unsigned DLY_T3  = 1100,
  parameter int unsigned DLY_T4  = 1400
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    tick,
  input  logic [MV_W-1:0]         cell_a_mv,
  input  logic [MV_W-1:0]         cell_b_mv,
  input  logic signed [SNS_W-1:0] sense_mv,
  input  logic [1:0]              trip_var,
  input  logic [2:0]              dly_sel,
  output logic                    chg_en,
  output logic                    dsg_en,
  output logic                    low_power
);
  localparam int unsigned NCELL = 2;
  // DLY_T4 is the longest window
  localparam int unsigned CNT_W = $clog2(DLY_T4 + 1);
  localparam logic signed [SNS_W-1:0] WAKE_L = SNS_W'(WAKE_MV);

  logic [NCELL-1:0][MV_W-1:0] cells;
  logic [MV_W-1:0]  hi_mv;
  logic [NCELL-1:0] over_hi, below_rel, under_lo, above_rel;
  logic [NCELL-1:0] oc_mask, oc_seen;
  logic [NCELL-1:0] oc_flag, od_flag;
  logic [NTMR-1:0]  run, expire;
  logic [CNT_W-1:0] limit;
  logic             chg_inh, dsg_inh;
  guard_mode_t      mode;
  logic             sleeping, charger, oc_clear, od_clear;

  assign cells[0] = cell_a_mv;
  assign cells[1] = cell_b_mv;

  always_comb begin
    case (trip_var)
      2'd0:    hi_mv = MV_W'(HI_MV0);
      2'd1:    hi_mv = MV_W'(HI_MV1);
      default: hi_mv = MV_W'(HI_MV2);
    endcase
  end

  cg_level_cmp #(
    .MV_W(MV_W), .NCELL(NCELL), .HI_REL(HI_REL), .LO_MV(LO_MV), .LO_REL(LO_REL)
  ) u_cmp (
    .cell_mv(cells), .hi_mv(hi_mv), .over_hi(over_hi), .below_rel(below_rel),
    .under_lo(under_lo), .above_rel(above_rel)
  );

  cg_delay_map #(
    .CNT_W(CNT_W), .T0(DLY_T0), .T1(DLY_T1), .T2(DLY_T2), .T3(DLY_T3), .T4(DLY_T4)
  ) u_dly (
    .code(dly_sel), .limit(limit)
  );

  assign sleeping = (mode == MODE_SLEEP);
  assign charger  = sense_mv < WAKE_L;
  // in sleep only cells that did not trip low keep overvoltage watch
  assign oc_mask  = sleeping ? ~od_flag : '1;
  assign oc_seen  = over_hi & oc_mask;

  assign run[TMR_OVC] = (|oc_seen) && !chg_inh;
  assign run[TMR_OVD] = (|under_lo) && !dsg_inh && !sleeping;

  for (genvar t = 0; t < NTMR; t++) begin : g_tmr
    cg_qual_timer #(.CNT_W(CNT_W)) u_tmr (
      .clk(clk), .rst(rst), .tick(tick), .run(run[t]), .limit(limit),
      .expire(expire[t])
    );
  end

  assign oc_clear = chg_inh && ((oc_flag & ~below_rel) == '0);
  assign od_clear = dsg_inh && !sleeping && ((od_flag & ~above_rel) == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      chg_inh <= 1'b0;
      dsg_inh <= 1'b0;
      oc_flag <= '0;
      od_flag <= '0;
      mode    <= MODE_RUN;
    end else begin
      if (expire[TMR_OVC]) begin
        chg_inh <= 1'b1;
        oc_flag <= oc_seen;
      end else if (oc_clear) begin
        chg_inh <= 1'b0;
        oc_flag <= '0;
      end

      if (expire[TMR_OVD]) begin
        dsg_inh <= 1'b1;
        od_flag <= under_lo;
        mode    <= MODE_SLEEP;
      end else begin
        if (sleeping && charger) mode <= MODE_RUN;
        if (od_clear) begin
          dsg_inh <= 1'b0;
          od_flag <= '0;
        end
      end
    end
  end

  assign chg_en    = ~chg_inh;
  assign dsg_en    = ~dsg_inh;
  assign low_power = sleeping;

  AST_OC_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $fell(chg_en) |-> $past(|over_hi)); // R1

  AST_OC_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (!chg_en && (|oc_flag) && ((oc_flag & below_rel) == oc_flag)) |=> chg_en); // R2

  AST_OD_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $fell(dsg_en) |-> ($past(|under_lo) && low_power)); // R3

  AST_SLEEP_HOLD: assert property (@(posedge clk) disable iff (rst)
    (low_power && !charger) |=> (low_power && !dsg_en)); // R6

  AST_WAKE: assert property (@(posedge clk) disable iff (rst)
    (low_power && charger) |=> !low_power); // R8

  AST_SLEEP_OVC_MASK: assert property (@(posedge clk) disable iff (rst)
    (low_power && $fell(chg_en)) |-> $past((over_hi & ~od_flag) != '0)); // R7

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (chg_en && dsg_en && !low_power)); // R11
endmodule

// File: tb/tb_cell_guard_ctrl.sv
module tb_cell_guard_ctrl;
  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              tick = 1'b1;
  logic [12:0]       ca = 13'd3700;
  logic [12:0]       cb = 13'd3700;
  logic signed [11:0] sns = 12'sd0;
  logic [1:0]        tvar = 2'd0;
  logic [2:0]        dsel = 3'd0;
  logic              chg, dsg, lp;
  int nchk  = 0;
  int nfail = 0;

  cell_guard_ctrl dut (
    .clk(clk), .rst(rst), .tick(tick), .cell_a_mv(ca), .cell_b_mv(cb),
    .sense_mv(sns), .trip_var(tvar), .dly_sel(dsel),
    .chg_en(chg), .dsg_en(dsg), .low_power(lp)
  );

  always #4 clk = ~clk;

  // vector: {cell_a, cell_b, sense, edges to hold, expected {chg,dsg,lp}}
  localparam int NV = 24;
  localparam logic [52:0] VEC [NV] = '{
    {13'd3700, 13'd3700, 12'h000, 12'd5,  3'b110}, // R1 idle
    {13'd4360, 13'd3700, 12'h000, 12'd24, 3'b110}, // R1 one short
    {13'd4360, 13'd3700, 12'h000, 12'd1,  3'b010}, // R1 trip
    {13'd4100, 13'd3700, 12'h000, 12'd3,  3'b010}, // R2 still high
    {13'd3990, 13'd4200, 12'h000, 12'd1,  3'b110}, // R2 release, other cell high
    {13'd3700, 13'd4351, 12'h000, 12'd10, 3'b110}, // R10 partial
    {13'd3700, 13'd3700, 12'h000, 12'd1,  3'b110}, // R10 excursion ends
    {13'd3700, 13'd4351, 12'h000, 12'd24, 3'b110}, // R10 restarted count
    {13'd3700, 13'd4351, 12'h000, 12'd1,  3'b010}, // R1 cell b trip
    {13'd3700, 13'd3995, 12'h000, 12'd1,  3'b110}, // R2
    {13'd2390, 13'd3700, 12'h000, 12'd24, 3'b110}, // R3 one short
    {13'd2390, 13'd3700, 12'h000, 12'd1,  3'b101}, // R3 R6 R9 trip
    {13'd3100, 13'd3700, 12'h000, 12'd5,  3'b101}, // R6 recovery ignored
    {13'd3100, 13'd3700, 12'hE70, 12'd3,  3'b101}, // R8 -400 no wake
    {13'd3100, 13'd3700, 12'hE6F, 12'd1,  3'b100}, // R8 -401 wakes
    {13'd3100, 13'd3700, 12'hE6F, 12'd1,  3'b110}, // R4 release
    {13'd2390, 13'd3700, 12'h000, 12'd25, 3'b101}, // R3 second trip
    {13'd2390, 13'd4360, 12'h000, 12'd24, 3'b101}, // R7 one short
    {13'd2390, 13'd4360, 12'h000, 12'd1,  3'b001}, // R7 trip in sleep
    {13'd2390, 13'd3990, 12'h000, 12'd1,  3'b101}, // R7 release in sleep
    {13'd2390, 13'd3700, 12'hE0C, 12'd1,  3'b100}, // R8 wake, cell low
    {13'd2390, 13'd3700, 12'hE0C, 12'd3,  3'b100}, // R9 R4 held
    {13'd3000, 13'd3700, 12'h000, 12'd2,  3'b100}, // R4 3000 not above
    {13'd3001, 13'd3700, 12'h000, 12'd1,  3'b110}  // R4 release
  };

  task automatic chk(input logic [2:0] exp, input string rq);
    nchk++;
    if ({chg, dsg, lp} !== exp) begin
      nfail++;
      $display("FAIL %s: {chg,dsg,lp} actual %b expected %b", rq, {chg, dsg, lp}, exp);
    end
  endtask

  task automatic hold(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset;
    @(negedge clk);
    rst = 1'b1;
    ca = 13'd3700; cb = 13'd3700; sns = 12'sd0;
    hold(1);
    rst = 1'b0;
  endtask

  task automatic run_var(input logic [1:0] v, input logic [12:0] thr);
    do_reset();
    tvar = v; dsel = 3'd0;
    ca = thr;
    hold(30);
    chk(3'b110, "R1 at level, no trip");
    ca = thr + 13'd1;
    hold(25);
    chk(3'b010, "R1 variant trip");
  endtask

  task automatic run_dly(input logic [2:0] code, input int n);
    do_reset();
    tvar = 2'd0; dsel = code;
    cb = 13'd4360;
    hold(n - 1);
    chk(3'b110, "R5 window minus one");
    hold(1);
    chk(3'b010, "R5 window end");
  endtask

  initial begin
    #(8 * 200000);
    nfail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    hold(2);
    chk(3'b110, "R11 reset state");
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      logic [11:0] h;
      logic [2:0]  e;
      {ca, cb, sns, h, e} = VEC[i];
      hold(int'(h));
      nchk++;
      if ({chg, dsg, lp} !== e) begin
        nfail++;
        $display("FAIL vector %0d (R-tag in table): actual %b expected %b", i, {chg, dsg, lp}, e);
      end
    end

    // R11: reset from a double trip clears state and counters
    ca = 13'd4360; cb = 13'd2390; sns = 12'sd0;
    hold(25);
    chk(3'b001, "R1 R3 both trip");
    rst = 1'b1;
    hold(1);
    chk(3'b110, "R11 reset clears trips");
    rst = 1'b0;
    hold(24);
    chk(3'b110, "R11 counters cleared");
    hold(1);
    chk(3'b001, "R11 full window after reset");

    run_var(2'd1, 13'd4300);
    run_var(2'd2, 13'd4250);
    run_var(2'd3, 13'd4250);

    run_dly(3'd1, 320);
    run_dly(3'd2, 850);
    run_dly(3'd3, 1100);
    run_dly(3'd4, 1400);
    run_dly(3'd7, 1400);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule